// File: doc/BRIEF.md
# I2C Line-to-Transaction Bridge

This block sits on the two wires of an I2C bus whose master toggles SCL and SDA in software. It samples both lines, finds START and STOP conditions and follows the bit sequence of each byte. From that it produces byte-level events on a target-side port: a start carrying the 7-bit address and direction, write bytes, read-byte requests, a NACK notice and an end-of-transfer notice. The port is meant for a model or controller of the addressed target. The block does not act as a target with its own registers.

During the acknowledge clock of every byte the master writes, the block pulls its own open-drain SDA output low. During a read it shifts the bytes supplied by the port onto SDA, most significant bit first. It returns the resolved bus level to the master, which is its own drive ANDed with the master's SDA. Events are one-cycle pulses. The read request is combinational, and the port must present the byte in the same cycle the request is high.

Top module: `i2c_line_bridge`

## Requirements
- R1: After reset the block's SDA drive and the reported SDA level are both high, the decoder is idle and no event pulse is active.
- R2: A falling SDA while SCL is high starts a transfer, or restarts one that is already open. The next eight bits are then taken as an address byte, and no event is raised by the condition itself.
- R3: A rising SDA while SCL is high ends the transfer and returns the decoder to idle. It raises `end_pulse` only if an address was captured since the last START.
- R4: A change of SDA while SCL is low is stored but never counts as START or STOP. This includes a change that arrives in the same sample as a falling SCL, because the SCL edge is handled first.
- R5: Bits the master writes are sampled on rising SCL, most significant first. On the rising SCL of the ninth clock after a START the block pulls SDA low and pulses `start_pulse`, with `start_addr` set to bits 7..1 of the byte and `start_read` set to bit 0.
- R6: Each later byte of a write-direction transfer is acknowledged in the same way and is reported by a `wr_pulse` with the byte on `wr_data`.
- R7: In a read-direction transfer, `rd_req` is high for one cycle at the first rising SCL of each byte, and `rd_data` is taken in that cycle. On each of the eight rising edges the block drives the next bit onto SDA, most significant first. Every falling SCL releases the drive to high.
- R8: On the rising SCL after eight read bits, a low SDA from the master continues with another read byte. A high SDA raises `nack_pulse` and enters a halted state. In that state clocks are ignored, SDA stays released and no request is made until the next START or STOP.
- R9: `sda_seen` is the AND of the block's own drive and the synchronised SDA level from the master.
- R10: `start_pulse`, `wr_pulse`, `nack_pulse`, `end_pulse` and `rd_req` each stay high for one clock cycle per occurrence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL level driven by the master |
| sda_in | input | 1 | SDA level driven by the master |
| rd_data | input | 8 | Read byte from the port, valid while `rd_req` is high |
| sda_drive | output | 1 | Block's open-drain SDA contribution (1 = released) |
| sda_seen | output | 1 | Resolved wired-AND SDA level returned to the master |
| start_pulse | output | 1 | Address byte received |
| start_addr | output | 7 | 7-bit target address of the transfer |
| start_read | output | 1 | Direction bit of the address byte (1 = read) |
| wr_pulse | output | 1 | Write data byte received |
| wr_data | output | 8 | Written byte |
| rd_req | output | 1 | Request for the next read byte |
| nack_pulse | output | 1 | Master refused a read byte |
| end_pulse | output | 1 | Transfer closed by STOP |

## Verification
The bench targets four hazards. The first is an SDA change with SCL low, and in particular one that coincides with a falling SCL: a decoder that mistakes it for a condition would either acknowledge an idle bus or drop an address that is in progress. The second is a STOP with no address captured, where a careless decoder would report a spurious end of transfer. The third is the halted state after a NACK: if it kept clocking, it would request bytes and drive SDA while the master expects a released line. The fourth is a repeated START inside a write, which must lead to a second address event rather than a data byte. Read bytes are checked bit by bit on the returned SDA, so a wrong shift order or a late load of the requested byte shows up as a wrong value.

// File: rtl/i2c_line_bridge.sv
module i2c_line_bridge #(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_drive,
  output logic              sda_seen,
  output logic              start_pulse,
  output logic [BYTE_W-2:0] start_addr,
  output logic              start_read,
  output logic              wr_pulse,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_req,
  output logic              nack_pulse,
  output logic              end_pulse
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WBIT, S_WACK, S_RBIT, S_RACK, S_HALT
  } st_t;

  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_s, sda_s, scl_q, sda_q;
  logic scl_rise, scl_fall, bus_evt, is_start, is_stop;
  st_t st;
  logic [CNT_W-1:0] cnt;
  logic [BYTE_W-1:0] shreg;
  logic have_addr, dir;

  assign scl_s    = scl_pipe[SYNC_STAGES-1];
  assign sda_s    = sda_pipe[SYNC_STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign bus_evt  = (sda_s ^ sda_q) & scl_s;
  assign is_start = bus_evt & ~sda_s;
  assign is_stop  = bus_evt & sda_s;
  assign rd_req   = scl_rise && (st == S_RBIT) && (cnt == '0);
  assign sda_seen = sda_drive & sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q       <= 1'b1;
      sda_q       <= 1'b1;
      st          <= S_IDLE;
      cnt         <= '0;
      shreg       <= '0;
      have_addr   <= 1'b0;
      dir         <= 1'b0;
      sda_drive   <= 1'b1;
      start_pulse <= 1'b0;
      start_addr  <= '0;
      start_read  <= 1'b0;
      wr_pulse    <= 1'b0;
      wr_data     <= '0;
      nack_pulse  <= 1'b0;
      end_pulse   <= 1'b0;
    end else begin
      scl_q       <= scl_s;
      sda_q       <= sda_s;
      start_pulse <= 1'b0;
      wr_pulse    <= 1'b0;
      nack_pulse  <= 1'b0;
      end_pulse   <= 1'b0;

      if (scl_fall) sda_drive <= 1'b1;

      if (scl_rise) begin
        case (st)
          S_WBIT: begin
            shreg     <= {shreg[BYTE_W-2:0], sda_q};
            sda_drive <= 1'b1;
            if (cnt == LAST_BIT) begin
              cnt <= '0;
              st  <= S_WACK;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_WACK: begin
            sda_drive <= 1'b0;
            cnt       <= '0;
            if (!have_addr) begin
              have_addr   <= 1'b1;
              dir         <= shreg[0];
              start_addr  <= shreg[BYTE_W-1:1];
              start_read  <= shreg[0];
              start_pulse <= 1'b1;
              st          <= shreg[0] ? S_RBIT : S_WBIT;
            end else begin
              wr_pulse <= 1'b1;
              wr_data  <= shreg;
              st       <= dir ? S_RBIT : S_WBIT;
            end
          end
          S_RBIT: begin
            if (cnt == '0) begin
              sda_drive <= rd_data[BYTE_W-1];
              shreg     <= {rd_data[BYTE_W-2:0], 1'b0};
            end else begin
              sda_drive <= shreg[BYTE_W-1];
              shreg     <= {shreg[BYTE_W-2:0], 1'b0};
            end
            if (cnt == LAST_BIT) begin
              cnt <= '0;
              st  <= S_RACK;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_RACK: begin
            sda_drive <= 1'b1;
            cnt       <= '0;
            if (sda_q) begin
              nack_pulse <= 1'b1;
              st         <= S_HALT;
            end else begin
              st <= S_RBIT;
            end
          end
          default: sda_drive <= 1'b1;
        endcase
      end

      if (is_start) begin
        st        <= S_WBIT;
        cnt       <= '0;
        have_addr <= 1'b0;
        sda_drive <= 1'b1;
      end

      if (is_stop) begin
        end_pulse <= have_addr;
        have_addr <= 1'b0;
        st        <= S_IDLE;
        cnt       <= '0;
        sda_drive <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_line_bridge_chk.sv
module i2c_line_bridge_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_drive,
  input logic sda_seen,
  input logic start_pulse,
  input logic wr_pulse,
  input logic nack_pulse,
  input logic end_pulse,
  input logic rd_req,
  input logic rd_msb,
  input logic bus_evt,
  input logic scl_fall
);
  assert_ack_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse || wr_pulse) && !$past(bus_evt) |-> !sda_drive);

  assert_nack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nack_pulse |-> sda_drive);

  assert_end_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    end_pulse |-> sda_drive);

  assert_read_msb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !bus_evt |=> sda_drive == $past(rd_msb));

  assert_fall_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |=> sda_drive);

  assert_seen_and_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sda_seen |-> sda_drive);

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse || wr_pulse || nack_pulse || rd_req) |=>
      !(start_pulse || wr_pulse || nack_pulse || rd_req));

  assert_end_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    end_pulse |=> !end_pulse);
endmodule

bind i2c_line_bridge i2c_line_bridge_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sda_drive  (sda_drive),
  .sda_seen   (sda_seen),
  .start_pulse(start_pulse),
  .wr_pulse   (wr_pulse),
  .nack_pulse (nack_pulse),
  .end_pulse  (end_pulse),
  .rd_req     (rd_req),
  .rd_msb     (rd_data[BYTE_W-1]),
  .bus_evt    (bus_evt),
  .scl_fall   (scl_fall)
);

// File: tb/sim_i2c_line_bridge.sv
`timescale 1ns/1ps
module sim_i2c_line_bridge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_in = 1'b1, sda_in = 1'b1;
  logic [7:0] rd_data = 8'h00;
  logic sda_drive, sda_seen, start_pulse, start_read, wr_pulse, rd_req, nack_pulse, end_pulse;
  logic [6:0] start_addr;
  logic [7:0] wr_data;

  always #2.5 clk = ~clk;

  i2c_line_bridge u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in), .rd_data(rd_data),
    .sda_drive(sda_drive), .sda_seen(sda_seen), .start_pulse(start_pulse),
    .start_addr(start_addr), .start_read(start_read), .wr_pulse(wr_pulse),
    .wr_data(wr_data), .rd_req(rd_req), .nack_pulse(nack_pulse), .end_pulse(end_pulse)
  );

  int checks = 0, errors = 0;
  int n_start = 0, n_wr = 0, n_rd = 0, n_nack = 0, n_end = 0, wide = 0;
  logic [6:0] last_addr = '0;
  logic last_dir = 1'b0;
  logic [7:0] last_wr = '0;
  logic prev_any = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (start_pulse) begin n_start++; last_addr = start_addr; last_dir = start_read; end
      if (wr_pulse) begin n_wr++; last_wr = wr_data; end
      if (rd_req) n_rd++;
      if (nack_pulse) n_nack++;
      if (end_pulse) n_end++;
      if (prev_any && (start_pulse | wr_pulse | rd_req | nack_pulse | end_pulse)) wide++;
      prev_any = start_pulse | wr_pulse | rd_req | nack_pulse | end_pulse;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold();
    repeat (6) @(negedge clk);
  endtask

  task automatic bus_start();
    if (!scl_in) begin sda_in = 1'b1; hold(); scl_in = 1'b1; hold(); end
    sda_in = 1'b0; hold();
    scl_in = 1'b0; hold();
  endtask

  task automatic bus_stop();
    sda_in = 1'b0; hold();
    scl_in = 1'b1; hold();
    sda_in = 1'b1; hold();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_in = b[i]; hold();
      scl_in = 1'b1; hold();
      scl_in = 1'b0; hold();
    end
    sda_in = 1'b1; hold();
    scl_in = 1'b1; hold();
    acked = !sda_seen;
    scl_in = 1'b0; hold();
  endtask

  task automatic recv_byte(input logic [7:0] b, input logic nack, output logic [7:0] got);
    rd_data = b;
    sda_in = 1'b1; hold();
    for (int i = 7; i >= 0; i--) begin
      scl_in = 1'b1; hold();
      got[i] = sda_seen;
      scl_in = 1'b0; hold();
    end
    sda_in = nack; hold();
    scl_in = 1'b1; hold();
    scl_in = 1'b0; hold();
  endtask

  localparam int NV = 17;
  localparam logic [2:0] OP_S = 3'd0, OP_A = 3'd1, OP_W = 3'd2, OP_R = 3'd3, OP_P = 3'd4;
  localparam logic [11:0] VEC [NV] = '{
    {OP_S, 1'b0, 8'h00}, {OP_A, 1'b0, 8'hA4}, {OP_W, 1'b0, 8'h3C}, {OP_W, 1'b0, 8'h81},
    {OP_P, 1'b1, 8'h00},
    {OP_S, 1'b0, 8'h00}, {OP_A, 1'b0, 8'hA5}, {OP_R, 1'b0, 8'hC3}, {OP_R, 1'b1, 8'h5A},
    {OP_P, 1'b1, 8'h00},
    {OP_S, 1'b0, 8'h00}, {OP_A, 1'b0, 8'h30}, {OP_W, 1'b0, 8'hFF},
    {OP_S, 1'b0, 8'h00}, {OP_A, 1'b0, 8'h31}, {OP_R, 1'b1, 8'h00},
    {OP_P, 1'b1, 8'h00}
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] got;
    int c0, c1, c2;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    hold();
    // R1 reset state
    chk(sda_drive && sda_seen, "R1 released after reset", {sda_drive, sda_seen}, 3);
    chk(n_start + n_wr + n_rd + n_nack + n_end == 0, "R1 no events after reset",
        n_start + n_wr + n_rd + n_nack + n_end, 0);

    for (int v = 0; v < NV; v++) begin
      logic [2:0] op = VEC[v][11:9];
      logic fl = VEC[v][8];
      logic [7:0] d = VEC[v][7:0];
      case (op)
        OP_S: begin
          c0 = n_start + n_wr + n_end;
          bus_start();
          chk(n_start + n_wr + n_end == c0, "R2 start raises no event", n_start + n_wr + n_end, c0);
        end
        OP_A: begin
          c0 = n_start;
          send_byte(d, ack);
          chk(ack, "R5 address acknowledged", ack, 1);
          chk(n_start == c0 + 1 && last_addr == d[7:1] && last_dir == d[0],
              "R2 R5 start event fields", {last_addr, last_dir}, d);
        end
        OP_W: begin
          c0 = n_wr;
          send_byte(d, ack);
          chk(ack, "R6 data acknowledged", ack, 1);
          chk(n_wr == c0 + 1 && last_wr == d, "R6 write event", last_wr, d);
        end
        OP_R: begin
          c0 = n_rd; c1 = n_nack;
          recv_byte(d, fl, got);
          chk(got == d, "R7 read bits on SDA", got, d);
          chk(n_rd == c0 + 1, "R7 one request per byte", n_rd - c0, 1);
          chk(n_nack - c1 == int'(fl), "R8 nack notice", n_nack - c1, fl);
        end
        default: begin
          c0 = n_end;
          bus_stop();
          chk(n_end - c0 == int'(fl), "R3 end event", n_end - c0, fl);
        end
      endcase
    end

    // R3 stop with no address
    c0 = n_end;
    bus_start();
    bus_stop();
    chk(n_end == c0, "R3 no end without address", n_end - c0, 0);

    // R8 halted state after NACK
    bus_start();
    send_byte(8'hA5, ack);
    recv_byte(8'h96, 1'b1, got);
    chk(got == 8'h96, "R7 read byte before nack", got, 8'h96);
    c0 = n_rd; c1 = n_start + n_wr; c2 = 0;
    sda_in = 1'b1; hold();
    for (int i = 0; i < 9; i++) begin
      scl_in = 1'b1; hold();
      if (!sda_seen) c2++;
      scl_in = 1'b0; hold();
    end
    chk(c2 == 0, "R8 SDA released while halted", c2, 0);
    chk(n_rd == c0 && n_start + n_wr == c1, "R8 clocks ignored while halted", n_rd - c0, 0);
    c0 = n_end;
    bus_stop();
    chk(n_end == c0 + 1, "R3 end after halted transfer", n_end - c0, 1);

    // R9 wired-AND readback in idle
    scl_in = 1'b0; hold();
    sda_in = 1'b0; hold();
    chk(!sda_seen, "R9 master low seen", sda_seen, 0);
    // R4 SDA toggles with SCL low are not conditions
    sda_in = 1'b1; hold();
    chk(sda_seen, "R9 master high seen", sda_seen, 1);
    sda_in = 1'b0; hold();
    sda_in = 1'b1; hold();
    c0 = n_start;
    send_byte(8'hA4, ack);
    chk(!ack && n_start == c0, "R4 no start from SDA with SCL low", ack, 0);
    scl_in = 1'b1; hold();

    // R4 SCL fall and SDA rise in the same sample is not a STOP
    sda_in = 1'b0; hold();
    @(negedge clk);
    scl_in = 1'b0; sda_in = 1'b1;
    hold();
    c0 = n_start; c1 = n_end;
    send_byte(8'hA4, ack);
    chk(ack && n_start == c0 + 1 && n_end == c1, "R4 coincident edges keep transfer",
        n_start - c0, 1);
    bus_stop();

    chk(wide == 0, "R10 single-cycle pulses", wide, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule